// File: doc/BRIEF.md
# Strip Recorder Byte Feeder

The feeder moves print data from an upstream valid/ready byte stream onto an 8-bit parallel bus that goes to a strip-chart recorder. For each byte it puts the value on the bus and waits a set number of clocks. It then drives an active-low latch strobe for a set number of clocks, and keeps the value on the bus for a further set number of clocks afterwards. The recorder paces the transfer. It pulls an active-low request line low when it can take a byte. The feeder sends exactly one byte for each low period of that line.

The recorder also drives an active-low line-start input. This input is low while the print head is at the start position of a line. The upstream stream tags the first byte of each line with a start-of-line flag. A flagged byte is not accepted until the line-start input is low. Both recorder inputs are asynchronous and pass through two-flop synchronizers. A host request produces an active-low reset pulse of fixed length to the recorder. A byte that is in flight when the request arrives is abandoned, and no strobe is issued for it.

Top module: `strip_byte_feeder`

## Requirements
- R1: While reset is held and just after it, the latch strobe and the recorder reset output are high, the bus reads 0x00 and `src_ready` is low while the request line is high.
- R2: The request input passes through two flip-flops. When `rec_req_n` falls with the feeder idle and armed, `src_ready` rises exactly two clock edges later.
- R3: An accepted byte is on `rec_data` for SETUP_CLKS clock cycles (default 2) before `rec_latch_n` falls.
- R4: `rec_latch_n` stays low for exactly STROBE_CLKS cycles (default 3) per byte.
- R5: After `rec_latch_n` rises, `rec_data` keeps the byte and `src_ready` stays low for HOLD_CLKS cycles (default 2).
- R6: Only one byte is accepted per request. After an accept, no further byte is taken until the synchronized request has been seen high and then low again.
- R7: A byte with `src_sol` set is held off (`src_ready` low, no strobe) until the synchronized `rec_linestart_n` is low. A byte without the flag does not depend on `rec_linestart_n`.
- R8: When `rec_reset_req` is sampled high, `rec_rst_n` is low for exactly RESET_CLKS cycles (default 4), starting at the next clock edge.
- R9: A reset request abandons any byte in flight, so no strobe is issued for it. `src_ready` is low while `rec_rst_n` is low. Afterwards the feeder is armed again, and the next byte goes out while the request is still held low.
- R10: Bytes come out on `rec_data` in arrival order with their values unchanged, and each one is latched by its own strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_data | input | 8 | Upstream byte |
| src_sol | input | 1 | Byte is the first of a new print line |
| src_valid | input | 1 | Upstream byte is valid |
| src_ready | output | 1 | Feeder accepts the byte on this cycle |
| rec_reset_req | input | 1 | Host request for a recorder reset pulse |
| rec_data | output | 8 | Parallel data bus to the recorder |
| rec_latch_n | output | 1 | Active-low latch strobe to the recorder |
| rec_req_n | input | 1 | Active-low byte request from the recorder (asynchronous) |
| rec_linestart_n | input | 1 | Active-low line-start input from the recorder (asynchronous) |
| rec_rst_n | output | 1 | Active-low reset pulse to the recorder |

## Verification
The assertions assume that the upstream side keeps `src_data` and `src_sol` steady while `src_valid` is high and the byte has not been accepted. They also assume that `rec_reset_req` is a synchronous pulse, and that each level of the recorder inputs lasts at least two clocks so that the synchronizers can see it. The stimulus changes every input only on falling clock edges. It drops `src_valid` right after the accepting edge. It raises the request line for at least two clocks between bytes, and it pulses the reset request for a single cycle.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

  typedef enum logic [1:0] {
    FS_IDLE   = 2'd0,
    FS_SETUP  = 2'd1,
    FS_STROBE = 2'd2,
    FS_HOLD   = 2'd3
  } feed_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sbf_sync.sv
module sbf_sync #(
  parameter int   WIDTH     = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q;
    logic stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= RESET_VAL;
        stable_q <= RESET_VAL;
      end else begin
        meta_q   <= async_i[g];
        stable_q <= meta_q;
      end
    end

    assign sync_o[g] = stable_q;
  end

endmodule

// File: rtl/sbf_pulse.sv
module sbf_pulse #(
  parameter int PULSE_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic busy_o
);

  localparam int CNT_W = $clog2(PULSE_CLKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (req_i) begin
      cnt_d = CNT_W'(PULSE_CLKS);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (cnt_q != '0);

  // R8
  pulse_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> (cnt_q == CNT_W'(PULSE_CLKS)));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(PULSE_CLKS));

endmodule

// File: rtl/sbf_seq.sv
module sbf_seq
  import sbf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SETUP_CLKS  = 2,
  parameter int STROBE_CLKS = 3,
  parameter int HOLD_CLKS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_s_i,
  input  logic              lstart_s_i,
  input  logic              abort_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic              src_sol_i,
  input  logic              src_valid_i,
  output logic              src_ready_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              strobe_o
);

  localparam int CNT_MAX = max3(SETUP_CLKS, STROBE_CLKS, HOLD_CLKS);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int LOW_W   = $clog2(STROBE_CLKS + 1);

  feed_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              armed_q, armed_d;
  logic [DATA_W-1:0] bus_q;
  logic              strobe_q;
  logic              accept;
  logic              line_ok;

  assign line_ok     = !src_sol_i || lstart_s_i;
  assign src_ready_o = (state_q == FS_IDLE) && armed_q && req_s_i && line_ok && !abort_i;
  assign accept      = src_valid_i && src_ready_o;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (abort_i) begin
      state_d = FS_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        FS_IDLE: begin
          if (accept) begin
            state_d = FS_SETUP;
            cnt_d   = CNT_W'(SETUP_CLKS - 1);
          end
        end
        FS_SETUP: begin
          if (cnt_q == '0) begin
            state_d = FS_STROBE;
            cnt_d   = CNT_W'(STROBE_CLKS - 1);
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        FS_STROBE: begin
          if (cnt_q == '0) begin
            state_d = FS_HOLD;
            cnt_d   = CNT_W'(HOLD_CLKS - 1);
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: begin
          if (cnt_q == '0) begin
            state_d = FS_IDLE;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    armed_d = armed_q;
    if (accept) begin
      armed_d = 1'b0;
    end else if (abort_i || !req_s_i) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= FS_IDLE;
      cnt_q    <= '0;
      armed_q  <= 1'b1;
      strobe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      armed_q  <= armed_d;
      strobe_q <= (state_d == FS_STROBE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= '0;
    end else if (accept) begin
      bus_q <= src_data_i;
    end
  end

  assign bus_o    = bus_q;
  assign strobe_o = strobe_q;

  // Checker-only count of strobe cycles
  logic [LOW_W-1:0] low_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
    end else if (strobe_q) begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end else begin
      low_cnt_q <= '0;
    end
  end

  // R4
  strobe_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> (low_cnt_q < LOW_W'(STROBE_CLKS)));

  // R4
  strobe_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobe_q) && !strobe_q && !$past(abort_i)) |->
      ($past(low_cnt_q) == LOW_W'(STROBE_CLKS - 1)));

  // R5
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != FS_IDLE) && $past(state_q != FS_IDLE)) |-> $stable(bus_q));

  // R6
  one_per_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !src_ready_o);

  // R7
  line_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && src_sol_i) |-> lstart_s_i);

endmodule

// File: rtl/strip_byte_feeder.sv
module strip_byte_feeder #(
  parameter int DATA_W      = 8,
  parameter int SETUP_CLKS  = 2,
  parameter int STROBE_CLKS = 3,
  parameter int HOLD_CLKS   = 2,
  parameter int RESET_CLKS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_sol,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic              rec_reset_req,
  output logic [DATA_W-1:0] rec_data,
  output logic              rec_latch_n,
  input  logic              rec_req_n,
  input  logic              rec_linestart_n,
  output logic              rec_rst_n
);

  localparam int SYNC_W = 2;

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] synced;
  logic              req_s;
  logic              lstart_s;
  logic              pulse_busy;
  logic              abort;
  logic              strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  assign raw_in = {rec_linestart_n, rec_req_n};

  sbf_sync #(
    .WIDTH     (SYNC_W),
    .RESET_VAL (1'b1)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i (raw_in),
    .sync_o  (synced)
  );

  assign req_s    = ~synced[0];
  assign lstart_s = ~synced[1];

  sbf_pulse #(
    .PULSE_CLKS (RESET_CLKS)
  ) u_pulse (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .req_i  (rec_reset_req),
    .busy_o (pulse_busy)
  );

  assign abort = rec_reset_req || pulse_busy;

  sbf_seq #(
    .DATA_W      (DATA_W),
    .SETUP_CLKS  (SETUP_CLKS),
    .STROBE_CLKS (STROBE_CLKS),
    .HOLD_CLKS   (HOLD_CLKS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_s_i     (req_s),
    .lstart_s_i  (lstart_s),
    .abort_i     (abort),
    .src_data_i  (src_data),
    .src_sol_i   (src_sol),
    .src_valid_i (src_valid),
    .src_ready_o (src_ready),
    .bus_o       (rec_data),
    .strobe_o    (strobe)
  );

  assign rec_latch_n = ~strobe;
  assign rec_rst_n   = ~pulse_busy;

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rec_rst_n |-> (rec_latch_n && !src_ready));

  // R2
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    src_ready |-> $past(!rec_req_n, 2));

endmodule

// File: tb/sim_strip_byte_feeder.sv
module sim_strip_byte_feeder;

  localparam int P_SETUP  = 2;
  localparam int P_STROBE = 3;
  localparam int P_HOLD   = 2;
  localparam int P_RESET  = 4;
  localparam int NVEC     = 6;

  // {start-of-line flag, byte}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 8'h12}, {1'b0, 8'h34}, {1'b0, 8'hFF},
    {1'b1, 8'h00}, {1'b0, 8'hA7}, {1'b0, 8'h81}
  };

  logic       clk;
  logic       rst_n;
  logic [7:0] src_data;
  logic       src_sol;
  logic       src_valid;
  logic       src_ready;
  logic       rec_reset_req;
  logic [7:0] rec_data;
  logic       rec_latch_n;
  logic       rec_req_n;
  logic       rec_linestart_n;
  logic       rec_rst_n;

  int checks = 0;
  int errors = 0;

  strip_byte_feeder #(
    .DATA_W      (8),
    .SETUP_CLKS  (P_SETUP),
    .STROBE_CLKS (P_STROBE),
    .HOLD_CLKS   (P_HOLD),
    .RESET_CLKS  (P_RESET)
  ) u0 (
    .clk             (clk),
    .rst_n           (rst_n),
    .src_data        (src_data),
    .src_sol         (src_sol),
    .src_valid       (src_valid),
    .src_ready       (src_ready),
    .rec_reset_req   (rec_reset_req),
    .rec_data        (rec_data),
    .rec_latch_n     (rec_latch_n),
    .rec_req_n       (rec_req_n),
    .rec_linestart_n (rec_linestart_n),
    .rec_rst_n       (rec_rst_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Sends one byte; called and returns at a falling edge.
  task automatic send(input logic [7:0] d, input logic sol);
    int n;
    int m;
    int low;
    src_data  = d;
    src_sol   = sol;
    src_valid = 1'b1;
    n = 0;
    while (!src_ready && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(src_ready, "R10 byte accepted", int'(src_ready), 1);
    @(negedge clk);
    src_valid = 1'b0;
    src_sol   = 1'b0;
    n = 0;
    while (rec_latch_n && n < 40) begin
      n++;
      @(negedge clk);
    end
    chk(n == P_SETUP, "R3 setup cycles", n, P_SETUP);
    chk(rec_data == d, "R10 bus value at strobe", int'(rec_data), int'(d));
    rec_req_n = 1'b1;
    m   = 0;
    low = 1;
    while (m < 40) begin
      @(negedge clk);
      m++;
      if (m == 2) rec_req_n = 1'b0;
      if (rec_latch_n) break;
      low++;
    end
    chk(low == P_STROBE, "R4 strobe width", low, P_STROBE);
    n = 0;
    while (!src_ready && n < 40) begin
      chk(rec_data == d, "R5 bus held after strobe", int'(rec_data), int'(d));
      n++;
      @(negedge clk);
    end
    chk(n == P_HOLD, "R5 hold cycles", n, P_HOLD);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int n;
    bit bad;
    rst_n           = 1'b0;
    src_data        = '0;
    src_sol         = 1'b0;
    src_valid       = 1'b0;
    rec_reset_req   = 1'b0;
    rec_req_n       = 1'b1;
    rec_linestart_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: during reset
    chk(rec_latch_n == 1'b1, "R1 strobe in reset", int'(rec_latch_n), 1);
    chk(rec_rst_n == 1'b1, "R1 recorder reset in reset", int'(rec_rst_n), 1);
    chk(rec_data == 8'h00, "R1 bus in reset", int'(rec_data), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: after release, no request yet
    chk(src_ready == 1'b0, "R1 ready without request", int'(src_ready), 0);
    chk(rec_latch_n && rec_rst_n, "R1 outputs idle after reset", int'({rec_latch_n, rec_rst_n}), 3);

    // R10: vector table
    rec_req_n = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][7:0], VEC[i][8]);
    end

    // R2: synchronizer latency
    rec_req_n = 1'b1;
    repeat (4) @(negedge clk);
    rec_req_n = 1'b0;
    @(negedge clk);
    chk(src_ready == 1'b0, "R2 ready after one edge", int'(src_ready), 0);
    @(negedge clk);
    chk(src_ready == 1'b1, "R2 ready after two edges", int'(src_ready), 1);

    // R6: one byte per request
    src_data  = 8'h5A;
    src_valid = 1'b1;
    @(negedge clk);
    src_valid = 1'b0;
    n = 0;
    while (rec_latch_n && n < 40) begin n++; @(negedge clk); end
    chk(rec_data == 8'h5A, "R6 first byte sent", int'(rec_data), 8'h5A);
    n = 0;
    while (!rec_latch_n && n < 40) begin n++; @(negedge clk); end
    src_data  = 8'hA5;
    src_valid = 1'b1;
    bad = 1'b0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (src_ready || !rec_latch_n) bad = 1'b1;
    end
    chk(!bad, "R6 no second byte on same request", int'(bad), 0);
    src_valid = 1'b0;
    rec_req_n = 1'b1;
    repeat (3) @(negedge clk);
    rec_req_n = 1'b0;
    send(8'hA5, 1'b0);

    // R7: start-of-line byte waits for line-start
    rec_linestart_n = 1'b1;
    repeat (3) @(negedge clk);
    src_data  = 8'hC3;
    src_sol   = 1'b1;
    src_valid = 1'b1;
    bad = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (src_ready || !rec_latch_n) bad = 1'b1;
    end
    chk(!bad, "R7 flagged byte held off", int'(bad), 0);
    rec_linestart_n = 1'b0;
    send(8'hC3, 1'b1);
    rec_linestart_n = 1'b1;
    repeat (3) @(negedge clk);
    send(8'h3C, 1'b0);
    rec_linestart_n = 1'b0;

    // R8 / R9: reset pulse during setup drops the byte
    src_data  = 8'h99;
    src_valid = 1'b1;
    @(negedge clk);
    src_valid     = 1'b0;
    rec_reset_req = 1'b1;
    @(negedge clk);
    rec_reset_req = 1'b0;
    n = 0;
    bad = 1'b0;
    while (!rec_rst_n && n < 40) begin
      if (src_ready || !rec_latch_n) bad = 1'b1;
      n++;
      @(negedge clk);
    end
    chk(n == P_RESET, "R8 reset pulse width", n, P_RESET);
    chk(!bad, "R9 quiet during reset pulse", int'(bad), 0);
    bad = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (!rec_latch_n) bad = 1'b1;
      @(negedge clk);
    end
    chk(!bad, "R9 dropped byte not strobed", int'(bad), 0);
    send(8'h66, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule